// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block sits between an analog comparator and the CPU. It owns the comparator's single control and status register and samples the digital result of the comparison. From that result it detects a chosen kind of output change, latches an interrupt flag and raises an interrupt request. It also drives the power-down of the comparator and the selection of its positive input. That input is either an external pin or an internal 1.22 V reference.

The CPU reads the register at any time through `reg_rdata` and writes it with a one-cycle `reg_wr_en` strobe. The comparator result `cmp_in` is asynchronous and passes through a two-flop synchronizer. An edge is a difference between the synchronized value and its copy from the previous cycle.

The internal reference is powered while it is selected or while brown-out detection is on. After each power-up it needs a start-up interval, modelled as `SETTLE_CYCLES` clock cycles. During that interval no comparator event is accepted.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: Register bit 5 is read-only and shows `cmp_in` after the two-flop synchronizer: a change on `cmp_in` appears in `reg_rdata[5]` after exactly two rising clock edges.
- R2: Bits 7 (disable), 6 (reference select), 3 (interrupt enable), 1 and 0 (mode code) read back what was last written. Bit 2 always reads 0. Writes to bit 5 have no effect.
- R3: With mode code 00 in bits 1..0, both a rising and a falling synchronized edge set the flag in bit 4 on the clock edge after the one that exposes the change.
- R4: Mode code 10 sets the flag only on a falling edge, and mode code 11 only on a rising edge.
- R5: Mode code 01 is reserved and never sets the flag.
- R6: Writing a one to bit 4 clears the flag, and writing a zero leaves it unchanged. If a one is written in the same cycle as a new event, the flag stays set.
- R7: A one-cycle pulse on `vec_ack` clears the flag.
- R8: `irq` is high exactly while the flag, bit 3 and `gie` are all 1.
- R9: After reset, bits 7, 6, 4, 3, 1 and 0 read 0, and bit 5 shows the level `cmp_in` held during reset.
- R10: `ref_sel` follows bit 6. `ref_pwr_en` is high while bit 6 or `bod_en` is 1.
- R11: When `ref_pwr_en` rises, `ref_ready` stays low for `SETTLE_CYCLES` cycles and then goes high. No comparator event sets the flag during that interval.
- R12: `cmp_pwrdn` follows bit 7, and while bit 7 is 1 no comparator event sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cmp_in | input | 1 | Asynchronous comparator result, 1 when the positive input is higher |
| bod_en | input | 1 | Brown-out detection enabled, keeps the reference powered |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Interrupt vector acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |
| cmp_pwrdn | output | 1 | Comparator power-down |
| ref_sel | output | 1 | Positive input from the internal reference when 1 |
| ref_pwr_en | output | 1 | Internal reference power enable |
| ref_ready | output | 1 | Reference powered and settled |

## Verification
Every mode code is combined with both a rising and a falling comparator transition. This separates the toggle, falling, rising and reserved decodings from one another. The flag-clear paths are driven on their own: a write of one, a write of zero, an acknowledge pulse, and a write of one landing in the same cycle as a fresh event, which tells priority apart. Toggles made while the reference is settling or while the comparator is disabled must leave the flag clear. All combinations of flag, enable and `gie` are swept to pin down the interrupt gate.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } cmp_mode_e;

  localparam int REG_W      = 8;
  localparam int BIT_DIS    = 7;
  localparam int BIT_REFSEL = 6;
  localparam int BIT_OUT    = 5;
  localparam int BIT_FLAG   = 4;
  localparam int BIT_IE     = 3;
  localparam int BIT_RSVD   = 2;

  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << BIT_DIS) | (REG_W'(1) << BIT_REFSEL) |
    (REG_W'(1) << BIT_IE) | REG_W'(3);

  // 1 when the step prev -> cur is an event for mode m
  function automatic logic evt_match(cmp_mode_e m, logic prev, logic cur);
    logic rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (m)
      MODE_TOGGLE: evt_match = rise | fall;
      MODE_FALL:   evt_match = fall;
      MODE_RISE:   evt_match = rise;
      default:     evt_match = 1'b0;
    endcase
  endfunction

  // keep only writable control bits
  function automatic logic [REG_W-1:0] ctl_merge(logic [REG_W-1:0] wdata);
    ctl_merge = wdata & WR_MASK;
  endfunction

endpackage

// File: rtl/cmp_sync_edge.sv
module cmp_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic prev_out
);
  logic meta_q, sync_q, prev_q;

  // no reset: the synchronizer keeps tracking the comparator through reset
  always_ff @(posedge clk) begin
    meta_q <= async_in;
    sync_q <= meta_q;
    prev_q <= sync_q;
  end

  assign sync_out = sync_q;
  assign prev_out = prev_q;

  assert_prev_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) or 1'b1 |=> prev_q == $past(sync_q));

endmodule

// File: rtl/ref_settle_timer.sv
module ref_settle_timer #(
  parameter int SETTLE_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  output logic busy,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

  logic          pwr_q;
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start = pwr_en & ~pwr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pwr_q <= pwr_en;
      if (!pwr_en)             cnt_q <= '0;
      else if (start)          cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy  = start | (cnt_q != '0);
  assign ready = pwr_en & ~busy;

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !pwr_q) |-> !ready);
  assert_count_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && pwr_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_ready_on_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> pwr_en);

endmodule

// File: rtl/cmp_evt_flag.sv
module cmp_evt_flag
  import cmp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmp_mode_e mode,
  input  logic      cmp_prev,
  input  logic      cmp_cur,
  input  logic      block,
  input  logic      clr_req,
  output logic      hit,
  output logic      flag
);
  logic flag_q;

  assign hit = ~block & evt_match(mode, cmp_prev, cmp_cur);

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (hit)     flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  assert_hit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  assert_rsvd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSVD && !flag_q) |=> !flag_q);
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit) |=> !flag_q);
  assert_block_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (block && !flag_q) |=> !flag_q);

endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cmp_in,
  input  logic       bod_en,
  input  logic       gie,
  input  logic       vec_ack,
  output logic       irq,
  output logic       cmp_pwrdn,
  output logic       ref_sel,
  output logic       ref_pwr_en,
  output logic       ref_ready
);
  logic [REG_W-1:0] ctl_q;
  logic             cmp_sync, cmp_prev;
  logic             settle_busy;
  logic             evt_hit, flag;
  logic             clr_req;
  logic             evt_block;
  cmp_mode_e        mode;

  always_ff @(posedge clk) begin
    if (!rst_n)         ctl_q <= '0;
    else if (reg_wr_en) ctl_q <= ctl_merge(reg_wdata);
  end

  assign mode       = cmp_mode_e'(ctl_q[1:0]);
  assign cmp_pwrdn  = ctl_q[BIT_DIS];
  assign ref_sel    = ctl_q[BIT_REFSEL];
  assign ref_pwr_en = ctl_q[BIT_REFSEL] | bod_en;
  assign clr_req    = (reg_wr_en & reg_wdata[BIT_FLAG]) | vec_ack;
  assign evt_block  = ctl_q[BIT_DIS] | settle_busy;

  cmp_sync_edge u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .sync_out (cmp_sync),
    .prev_out (cmp_prev)
  );

  ref_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_en (ref_pwr_en),
    .busy   (settle_busy),
    .ready  (ref_ready)
  );

  cmp_evt_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cmp_prev (cmp_prev),
    .cmp_cur  (cmp_sync),
    .block    (evt_block),
    .clr_req  (clr_req),
    .hit      (evt_hit),
    .flag     (flag)
  );

  always_comb begin
    reg_rdata           = ctl_q & WR_MASK;
    reg_rdata[BIT_OUT]  = cmp_sync;
    reg_rdata[BIT_FLAG] = flag;
    reg_rdata[BIT_RSVD] = 1'b0;
  end

  assign irq = flag & ctl_q[BIT_IE] & gie;

  assert_irq_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);
  assert_disable_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pwrdn |-> !evt_hit);
  assert_settle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pwr_en && !ref_ready) |-> !evt_hit);
  assert_write_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_rdata[7:6] == $past(reg_wdata[7:6])) &&
                  (reg_rdata[3] == $past(reg_wdata[3])) &&
                  (reg_rdata[1:0] == $past(reg_wdata[1:0])));

endmodule

// File: tb/tb_cmp_evt_ctrl.sv
module tb_cmp_evt_ctrl;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cmp_in = 1'b1;
  logic       bod_en = 1'b0;
  logic       gie = 1'b0;
  logic       vec_ack = 1'b0;
  logic       irq, cmp_pwrdn, ref_sel, ref_pwr_en, ref_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_evt_ctrl #(.SETTLE_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_in(cmp_in), .bod_en(bod_en), .gie(gie),
    .vec_ack(vec_ack), .irq(irq), .cmp_pwrdn(cmp_pwrdn), .ref_sel(ref_sel),
    .ref_pwr_en(ref_pwr_en), .ref_ready(ref_ready)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wdata = 8'h00;
  endtask

  function automatic logic expect_flag(int m, bit rising);
    if (m == 0) return 1'b1;
    if (m == 2) return !rising;
    if (m == 3) return rising;
    return 1'b0;
  endfunction

  function automatic logic flag_of(logic [7:0] r);
    return r[4];
  endfunction

  initial begin
    @(negedge clk);
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset values with cmp_in held high
    chk("R9 reset", reg_rdata, 8'h20);
    chk("R8 irq after reset", {7'b0, irq}, 8'h00);

    // R1: two-edge synchronizer latency
    cmp_in = 1'b0;
    step(1);
    chk("R1 latency 1", {7'b0, reg_rdata[5]}, 8'h01);
    step(1);
    chk("R1 latency 2", {7'b0, reg_rdata[5]}, 8'h00);

    // R2: writable bits readback, bit2 zero, bit5 ignored
    wr(8'hFF);
    chk("R2 readback ff", reg_rdata & 8'hEF, 8'hCB);
    chk("R10 ref_sel", {6'b0, ref_sel, ref_pwr_en}, 8'h03);
    chk("R12 pwrdn", {7'b0, cmp_pwrdn}, 8'h01);
    wr(8'h39);
    chk("R2 readback 39", reg_rdata & 8'hEF, 8'h09);
    wr(8'h10);
    chk("R2 clear", reg_rdata, 8'h00);

    // R3/R4/R5: every mode with both edge directions
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        bit rising = (d == 1);
        cmp_in = !rising;
        step(4);
        wr(8'h10 | 8'(m));
        step(1);
        chk("R6 pre-clear", {7'b0, flag_of(reg_rdata)}, 8'h00);
        cmp_in = rising;
        step(2);
        chk("R3 no early flag", {7'b0, flag_of(reg_rdata)}, 8'h00);
        step(1);
        if (m == 1)
          chk("R5 reserved mode", {7'b0, flag_of(reg_rdata)},
              {7'b0, expect_flag(m, rising)});
        else if (m == 0)
          chk("R3 toggle mode", {7'b0, flag_of(reg_rdata)},
              {7'b0, expect_flag(m, rising)});
        else
          chk("R4 edge mode", {7'b0, flag_of(reg_rdata)},
              {7'b0, expect_flag(m, rising)});
      end
    end

    // R6: write zero keeps flag, write one clears it (flag now set, mode 11)
    cmp_in = 1'b0;
    wr(8'h00);
    step(4);
    cmp_in = 1'b1;
    step(3);
    chk("R6 flag set", {7'b0, flag_of(reg_rdata)}, 8'h01);
    wr(8'h00);
    chk("R6 write zero keeps", {7'b0, flag_of(reg_rdata)}, 8'h01);
    wr(8'h10);
    chk("R6 write one clears", {7'b0, flag_of(reg_rdata)}, 8'h00);

    // R6: collision of clear and new event (mode 00)
    cmp_in = 1'b0;
    step(2);
    wr(8'h10);
    chk("R6 collision keeps flag", {7'b0, flag_of(reg_rdata)}, 8'h01);

    // R7: acknowledge clears
    vec_ack = 1'b1;
    step(1);
    vec_ack = 1'b0;
    chk("R7 ack clears", {7'b0, flag_of(reg_rdata)}, 8'h00);

    // R8: irq gate sweep, flag set by a toggle
    cmp_in = 1'b1;
    step(3);
    for (int k = 0; k < 4; k++) begin
      bit ie = k[0];
      bit g  = k[1];
      wr({4'b0, ie, 3'b000});
      gie = g;
      #1;
      chk("R8 irq gate", {7'b0, irq}, {7'b0, ie & g});
    end
    wr(8'h18);
    gie = 1'b1;
    #1;
    chk("R8 irq no flag", {7'b0, irq}, 8'h00);
    gie = 1'b0;
    wr(8'h10);

    // R10: brown-out keeps reference powered
    bod_en = 1'b1;
    #1;
    chk("R10 bod power", {6'b0, ref_sel, ref_pwr_en}, 8'h01);
    bod_en = 1'b0;
    #1;
    chk("R10 power off", {7'b0, ref_pwr_en}, 8'h00);
    step(2);

    // R11: settle window and blocked events (mode 00)
    wr(8'h40);
    cmp_in = 1'b0;
    step(N - 1);
    chk("R11 not ready", {7'b0, ref_ready}, 8'h00);
    step(1);
    chk("R11 ready", {7'b0, ref_ready}, 8'h01);
    chk("R11 event blocked", {7'b0, flag_of(reg_rdata)}, 8'h00);
    cmp_in = 1'b1;
    step(3);
    chk("R11 event after ready", {7'b0, flag_of(reg_rdata)}, 8'h01);
    wr(8'h10);

    // R12: disabled comparator ignores events
    wr(8'h80);
    cmp_in = 1'b0;
    step(4);
    chk("R12 disabled no flag", {7'b0, flag_of(reg_rdata)}, 8'h00);
    chk("R12 pwrdn high", {7'b0, cmp_pwrdn}, 8'h01);
    wr(8'h00);
    chk("R12 pwrdn low", {7'b0, cmp_pwrdn}, 8'h00);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule